// File: doc/BRIEF.md
# Legacy System Control Port Block

This block is a set of byte-wide registers reached through I/O space. It decodes five fixed port addresses. Two ports carry power-management traffic: one is a command port that also requests a management interrupt, and the other is a scratch status port. Two ports hold the edge/level trigger mode vectors for the primary and secondary interrupt controllers. The last port requests a hard or a soft system reset.

A host bus adapter drives a 16-bit port address, a write byte, and single-cycle read and write strobes. The block samples read data and returns it on `io_rdata` in the cycle after the read strobe. Each register keeps only the bits of a write that its fixed mask allows, so reserved interrupt lines can never be set to level mode. The management-interrupt and reset requests are one-cycle registered pulses. The interrupt controllers and the reset sequencer that consume them are outside this block.

Top module: `sysport_regs`

## Requirements
- R1: Port 0x00B2 is the command register, 0x00B3 the status register, 0x04D0 the primary mode register, 0x04D1 the secondary mode register and 0x0CF9 the reset register. A read strobe on a mapped port returns that register's stored value on `io_rdata` one clock later.
- R2: A read strobe on any other address returns 0xFF one clock later.
- R3: A write to 0x00B2 stores the full byte. In the next cycle it raises `smi_pulse` for exactly one cycle, with `smi_code` equal to the written byte.
- R4: A write to 0x00B3 stores the full byte and raises no management-interrupt or reset pulse.
- R5: The primary mode register keeps only bits 7..3 of a write (mask 0xF8). `pri_mode` drives its value.
- R6: The secondary mode register keeps only bits 7,6,4,3,2,1 of a write (mask 0xDE). `sec_mode` drives its value.
- R7: The reset register stores only bit 1 of a write. The other bits always read back as zero.
- R8: A reset-register write with bit 2 set raises `hard_rst_req` for one cycle if bit 1 of that same write is set, and `soft_rst_req` for one cycle otherwise. Bit 2 clear gives no pulse. The pulse appears in the cycle after the write.
- R9: A write to an unmapped address changes no register and raises no pulse.
- R10: Synchronous reset clears all five registers and both mode outputs to zero and holds every pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read byte, valid the cycle after `io_rd` |
| pri_mode | output | 8 | Primary controller edge/level vector |
| sec_mode | output | 8 | Secondary controller edge/level vector |
| smi_pulse | output | 1 | One-cycle management-interrupt request |
| smi_code | output | 8 | Command byte carried with the request |
| hard_rst_req | output | 1 | One-cycle hard reset request |
| soft_rst_req | output | 1 | One-cycle soft reset request |

## Verification
A wrong stored value shows up on the port in two ways. The mode registers drive `pri_mode` and `sec_mode` directly, so any fault appears in the cycle after the write. A fault in any register also appears on `io_rdata` one cycle after a read of its port. Decode errors show up as a neighbour's register changing, as a spurious pulse, or as 0xFF being returned for a mapped port. The bench catches these by reading all five ports back after every disturbing access. A wrong hard/soft decision is visible at the pulse outputs in the single cycle after the reset-register write.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
  localparam int PORT_AW = 16;
  localparam int BYTE_W  = 8;

  localparam logic [PORT_AW-1:0] PORT_CMD = 16'h00B2;
  localparam logic [PORT_AW-1:0] PORT_STS = 16'h00B3;
  localparam logic [PORT_AW-1:0] PORT_PRI = 16'h04D0;
  localparam logic [PORT_AW-1:0] PORT_SEC = 16'h04D1;
  localparam logic [PORT_AW-1:0] PORT_RST = 16'h0CF9;

  localparam logic [BYTE_W-1:0] KEEP_ALL  = 8'hFF;
  localparam logic [BYTE_W-1:0] KEEP_PRI  = 8'hF8;
  localparam logic [BYTE_W-1:0] KEEP_SEC  = 8'hDE;
  localparam logic [BYTE_W-1:0] KEEP_RST  = 8'h02;
  localparam logic [BYTE_W-1:0] OPEN_BUS  = 8'hFF;

  localparam int RST_KIND_BIT = 1;
  localparam int RST_GO_BIT   = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_STS, SEL_PRI, SEL_SEC, SEL_RST
  } port_sel_e;
endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int AW = PORT_AW
) (
  input  logic [AW-1:0] addr,
  output port_sel_e     sel
);
  always_comb begin
    unique case (addr)
      PORT_CMD: sel = SEL_CMD;
      PORT_STS: sel = SEL_STS;
      PORT_PRI: sel = SEL_PRI;
      PORT_SEC: sel = SEL_SEC;
      PORT_RST: sel = SEL_RST;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sysport_bytereg.sv
module sysport_bytereg #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   KEEP      = '1,
  parameter bit             ON_CHANGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] masked;
  logic         load;

  assign masked = d & KEEP;

  generate
    if (ON_CHANGE) begin : g_cmp
      assign load = we && (masked != q);
    end else begin : g_plain
      assign load = we;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= masked;
  end
endmodule

// File: rtl/sysport_rstctl.sv
module sysport_rstctl
  import sysport_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic         hard_req,
  output logic         soft_req
);
  logic go;
  assign go = we && d[RST_GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_req <= 1'b0;
      soft_req <= 1'b0;
    end else begin
      hard_req <= go &&  d[RST_KIND_BIT];
      soft_req <= go && !d[RST_KIND_BIT];
    end
  end
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int AW = PORT_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] pri_mode,
  output logic [DW-1:0] sec_mode,
  output logic          smi_pulse,
  output logic [DW-1:0] smi_code,
  output logic          hard_rst_req,
  output logic          soft_rst_req
);
  port_sel_e     sel;
  logic [DW-1:0] cmd_q, sts_q, rst_q;

  sysport_decode #(.AW(AW)) u_dec (.addr(io_addr), .sel(sel));

  sysport_bytereg #(.W(DW), .KEEP(KEEP_ALL), .ON_CHANGE(1'b0)) u_cmd (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_CMD), .d(io_wdata), .q(cmd_q));
  sysport_bytereg #(.W(DW), .KEEP(KEEP_ALL), .ON_CHANGE(1'b0)) u_sts (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_STS), .d(io_wdata), .q(sts_q));
  sysport_bytereg #(.W(DW), .KEEP(KEEP_PRI), .ON_CHANGE(1'b1)) u_pri (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_PRI), .d(io_wdata), .q(pri_mode));
  sysport_bytereg #(.W(DW), .KEEP(KEEP_SEC), .ON_CHANGE(1'b1)) u_sec (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_SEC), .d(io_wdata), .q(sec_mode));
  sysport_bytereg #(.W(DW), .KEEP(KEEP_RST), .ON_CHANGE(1'b0)) u_rst (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_RST), .d(io_wdata), .q(rst_q));

  sysport_rstctl #(.W(DW)) u_rctl (
    .clk(clk), .rst(rst), .we(io_wr && sel == SEL_RST), .d(io_wdata),
    .hard_req(hard_rst_req), .soft_req(soft_rst_req));

  assign smi_code = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) smi_pulse <= 1'b0;
    else     smi_pulse <= io_wr && sel == SEL_CMD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      unique case (sel)
        SEL_CMD: io_rdata <= cmd_q;
        SEL_STS: io_rdata <= sts_q;
        SEL_PRI: io_rdata <= pri_mode;
        SEL_SEC: io_rdata <= sec_mode;
        SEL_RST: io_rdata <= rst_q;
        default: io_rdata <= OPEN_BUS;
      endcase
    end
  end
endmodule

// File: rtl/sysport_regs_chk.sv
module sysport_regs_chk
  import sysport_pkg::*;
#(
  parameter int AW = PORT_AW,
  parameter int DW = BYTE_W
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic          io_wr,
  input logic [DW-1:0] pri_mode,
  input logic [DW-1:0] sec_mode,
  input logic          smi_pulse,
  input logic          hard_rst_req,
  input logic          soft_rst_req
);
  assert_smi_cause_R3: assert property (@(posedge clk) disable iff (rst)
    smi_pulse |-> $past(io_wr && io_addr == PORT_CMD));
  assert_smi_single_R3: assert property (@(posedge clk) disable iff (rst)
    smi_pulse |=> !smi_pulse || $past(io_wr && io_addr == PORT_CMD));
  assert_pri_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (pri_mode & ~KEEP_PRI) == '0);
  assert_sec_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (sec_mode & ~KEEP_SEC) == '0);
  assert_pri_cause_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pri_mode) |-> $past(io_wr && io_addr == PORT_PRI));
  assert_hard_cause_R8: assert property (@(posedge clk) disable iff (rst)
    hard_rst_req |-> $past(io_wr && io_addr == PORT_RST && io_wdata[RST_GO_BIT] && io_wdata[RST_KIND_BIT]));
  assert_soft_cause_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> $past(io_wr && io_addr == PORT_RST && io_wdata[RST_GO_BIT] && !io_wdata[RST_KIND_BIT]));
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(hard_rst_req && soft_rst_req));
endmodule

bind sysport_regs sysport_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .pri_mode(pri_mode), .sec_mode(sec_mode), .smi_pulse(smi_pulse),
  .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req));

// File: tb/sysport_regs_test.sv
module sysport_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata, pri_mode, sec_mode, smi_code;
  logic        smi_pulse, hard_rst_req, soft_rst_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  sysport_regs uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .pri_mode(pri_mode), .sec_mode(sec_mode),
    .smi_pulse(smi_pulse), .smi_code(smi_code), .hard_rst_req(hard_rst_req),
    .soft_rst_req(soft_rst_req));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // monitor: pops one expected byte per read strobe seen
  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 8'h01, 8'h00);
      else check(tag_q.pop_front(), io_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // write, then check pulses in the cycle after and the cycle after that
  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input bit e_smi, input bit e_hard, input bit e_soft, input string req);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
    check({req, " smi"},  {7'd0, smi_pulse},    {7'd0, e_smi});
    check({req, " hard"}, {7'd0, hard_rst_req}, {7'd0, e_hard});
    check({req, " soft"}, {7'd0, soft_rst_req}, {7'd0, e_soft});
    if (e_smi) check({req, " code"}, smi_code, d);
    @(negedge clk);
    check({req, " pulse end"}, {5'd0, smi_pulse, hard_rst_req, soft_rst_req}, 8'h00);
  endtask

  task automatic read_all(input logic [7:0] c, s, p, q, r, input string req);
    rd(16'h00B2, c, {req, " cmd"});
    rd(16'h00B3, s, {req, " sts"});
    rd(16'h04D0, p, {req, " pri"});
    rd(16'h04D1, q, {req, " sec"});
    rd(16'h0CF9, r, {req, " rst"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 pri", pri_mode, 8'h00);
    check("R10 sec", sec_mode, 8'h00);
    check("R10 pulses", {5'd0, smi_pulse, hard_rst_req, soft_rst_req}, 8'h00);
    read_all(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R10");
    // R2 unmapped reads
    rd(16'h00B4, 8'hFF, "R2 b4");
    rd(16'h04D2, 8'hFF, "R2 4d2");
    rd(16'h0000, 8'hFF, "R2 0");
    // R3 command
    wr(16'h00B2, 8'hA5, 1, 0, 0, "R3");
    // R4 status
    wr(16'h00B3, 8'h3C, 0, 0, 0, "R4");
    read_all(8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00, "R1 after cmd/sts");
    // R5 primary mask
    wr(16'h04D0, 8'hFF, 0, 0, 0, "R5");
    check("R5 pri out", pri_mode, 8'hF8);
    wr(16'h04D0, 8'h07, 0, 0, 0, "R5 low bits");
    check("R5 pri cleared", pri_mode, 8'h00);
    wr(16'h04D0, 8'h5A, 0, 0, 0, "R5 pattern");
    check("R5 pri pattern", pri_mode, 8'h58);
    // R6 secondary mask
    wr(16'h04D1, 8'hFF, 0, 0, 0, "R6");
    check("R6 sec out", sec_mode, 8'hDE);
    wr(16'h04D1, 8'h21, 0, 0, 0, "R6 reserved");
    check("R6 sec reserved", sec_mode, 8'h00);
    wr(16'h04D1, 8'h96, 0, 0, 0, "R6 pattern");
    check("R6 sec pattern", sec_mode, 8'h96);
    // R7 reset register keeps bit 1
    wr(16'h0CF9, 8'hFB, 0, 0, 0, "R7");
    read_all(8'hA5, 8'h3C, 8'h58, 8'h96, 8'h02, "R1 R7");
    // R8 hard / soft
    wr(16'h0CF9, 8'h06, 0, 1, 0, "R8 hard");
    wr(16'h0CF9, 8'h04, 0, 0, 1, "R8 soft");
    rd(16'h0CF9, 8'h00, "R8 R7 stored");
    wr(16'h0CF9, 8'hFE, 0, 1, 0, "R8 hard all bits");
    // R9 unmapped writes
    wr(16'h00B1, 8'hFF, 0, 0, 0, "R9 b1");
    wr(16'h04D2, 8'hFF, 0, 0, 0, "R9 4d2");
    wr(16'h1CF9, 8'h06, 0, 0, 0, "R9 alias");
    check("R9 pri", pri_mode, 8'h58);
    check("R9 sec", sec_mode, 8'h96);
    read_all(8'hA5, 8'h3C, 8'h58, 8'h96, 8'h02, "R9");
    // R3 second command byte
    wr(16'h00B2, 8'h0F, 1, 0, 0, "R3 second");
    // R10 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R10 pri again", pri_mode, 8'h00);
    check("R10 sec again", sec_mode, 8'h00);
    read_all(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R10 again");
    repeat (2) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule